// File: doc/BRIEF.md
# Serial Track Packet Framer and Checker

This block sits after a bit demodulator on a model-railway command bus. It takes one decoded bit per strobe and looks for a run of ones (the preamble). It then waits for the 0 start bit that ends the preamble. From that point it assembles data bytes, each one most significant bit first. The single bit after each byte decides what comes next: a 0 means another byte follows, and a 1 ends the packet.

When the packet ends, the block checks two things. The packet must hold between three and six bytes. The XOR of all received bytes, including the final check byte, must be zero. A good packet produces a one-cycle valid strobe, with the bytes and their count on the outputs. A bad packet produces a one-cycle error strobe. A packet that grows past six bytes is dropped at the separator that would open a seventh byte, and the block goes back to hunting for a preamble. Decoding addresses or instructions is left to the logic downstream.

Top module: `dcc_pkt_framer`

## Requirements
- R1: After reset, `pkt_ok` and `pkt_err` are low, `pkt_len` is 0, `pkt_bytes` is all zero, and the block is hunting for a preamble.
- R2: A 0 bit is taken as a start bit only if at least PRE_MIN (default 10) strobed 1 bits come directly before it. A 0 that follows a shorter run of ones, and every bit after it up to the next valid preamble, produces no strobe.
- R3: Each byte is assembled from 8 strobed bits, most significant bit first. The first byte of a packet appears in `pkt_bytes[7:0]`, the second in `pkt_bytes[15:8]`, and so on.
- R4: After each byte, a 0 bit announces another byte and a 1 bit ends the packet.
- R5: A packet that ends with a byte count from MIN_BYTES (3) to MAX_BYTES (6) and an all-byte XOR of zero raises `pkt_ok` for exactly one cycle. The pulse appears in the cycle after the edge that samples the stop bit. `pkt_len` and `pkt_bytes` show the packet from that cycle on, with slots at and above `pkt_len` set to zero.
- R6: A packet whose all-byte XOR is non-zero raises `pkt_err` for one cycle and leaves `pkt_len` and `pkt_bytes` unchanged.
- R7: A packet that ends with fewer than MIN_BYTES bytes raises `pkt_err` for one cycle and leaves the outputs unchanged.
- R8: A 0 separator after the sixth byte raises `pkt_err` in the next cycle and returns the block to preamble hunting. The bits that follow produce no strobe until a fresh valid preamble arrives.
- R9: `bit_val` is ignored whenever `bit_vld` is low, and no strobe follows a cycle without `bit_vld`.
- R10: The stop bit does not count toward the next preamble. A new packet needs PRE_MIN fresh 1 bits after the stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe marking a new decoded bit |
| bit_val | input | 1 | Value of the decoded bit |
| pkt_ok | output | 1 | One-cycle pulse for a good packet |
| pkt_err | output | 1 | One-cycle pulse for a length or XOR fault |
| pkt_len | output | $clog2(MAX_BYTES+1) | Byte count of the last good packet |
| pkt_bytes | output | 8*MAX_BYTES | Bytes of the last good packet, first byte lowest |

## Verification
The bench targets several boundary cases, each paired with the failure it would expose:
- **Preamble boundary (exactly ten ones vs. nine).** A design with an off-by-one threshold would accept the nine-one case or reject the ten-one case.
- **Preamble right after a stop bit.** A framer that counts the stop bit as preamble would accept a packet after only nine new ones.
- **Length edges (one, two, six and seven bytes).** A counter that is off by one would either pass short packets or flag maximum-length ones. It would also raise its overrun error one byte late, or not at all.
- **Corrupted check bytes and error persistence.** A design that stores bytes on error would change `pkt_len` and `pkt_bytes` when it should hold them.
- **Random data with random gaps.** Random bit values during the gaps between strobes expose any logic that samples `bit_val` without `bit_vld`.

// File: rtl/dcc_pkt_pkg.sv
package dcc_pkt_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_BYTE = 2'd1,
    ST_SEP  = 2'd2
  } frame_st_t;

  // Append one bit at the low end: earlier bits end up in the high positions.
  function automatic logic [7:0] msb_first_push(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction

  // Fold a new byte into the running parity.
  function automatic logic [7:0] parity_add(input logic [7:0] acc, input logic [7:0] b);
    return acc ^ b;
  endfunction

endpackage

// File: rtl/dcc_preamble_det.sv
module dcc_preamble_det #(
  parameter int PRE_MIN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_val,
  input  logic hunting,
  output logic pre_ok
);
  localparam int PW = $clog2(PRE_MIN + 1);
  localparam logic [PW-1:0] PRE_LIM = PW'(PRE_MIN);

  logic [PW-1:0] ones_q;

  // Counts only while hunting; the start bit clears it and it stays at
  // zero for the whole packet, so the stop bit never adds to it.
  always_ff @(posedge clk) begin
    if (!rst_n)
      ones_q <= '0;
    else if (bit_stb && hunting) begin
      if (!bit_val)
        ones_q <= '0;
      else if (ones_q != PRE_LIM)
        ones_q <= ones_q + 1'b1;
    end
  end

  assign pre_ok = (ones_q >= PRE_LIM);

  assert_ones_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= PRE_LIM);

  assert_zero_in_pkt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hunting |-> ones_q == '0);

endmodule

// File: rtl/dcc_byte_shift.sv
module dcc_byte_shift
  import dcc_pkt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       in_byte,
  input  logic       bit_val,
  output logic       byte_done,
  output logic [7:0] byte_nxt
);
  logic [7:0] sr_q;
  logic [2:0] idx_q;

  assign byte_nxt  = msb_first_push(sr_q, bit_val);
  assign byte_done = shift_en && (idx_q == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (shift_en) begin
      sr_q  <= byte_nxt;
      idx_q <= idx_q + 3'd1;
    end
  end

  assert_idx_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_byte |-> idx_q == 3'd0);

endmodule

// File: rtl/dcc_frame_ctl.sv
module dcc_frame_ctl
  import dcc_pkt_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int MIN_BYTES = 3,
  parameter int CW        = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_stb,
  input  logic                        bit_val,
  input  logic                        pre_ok,
  input  logic                        byte_done,
  input  logic [7:0]                  byte_nxt,
  output logic                        in_hunt,
  output logic                        in_byte,
  output logic [CW-1:0]               cnt_q,
  output logic [MAX_BYTES-1:0][7:0]   cap_q,
  output logic                        ev_good,
  output logic                        ev_short,
  output logic                        ev_crc,
  output logic                        ev_overrun
);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_BYTES);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_BYTES);

  frame_st_t  state_q, state_d;
  logic [7:0] par_q;
  logic       ev_start;

  always_comb begin
    state_d    = state_q;
    ev_start   = 1'b0;
    ev_good    = 1'b0;
    ev_short   = 1'b0;
    ev_crc     = 1'b0;
    ev_overrun = 1'b0;
    case (state_q)
      ST_HUNT: if (bit_stb && !bit_val && pre_ok) begin
        ev_start = 1'b1;
        state_d  = ST_BYTE;
      end
      ST_BYTE: if (byte_done) state_d = ST_SEP;
      ST_SEP: if (bit_stb) begin
        if (!bit_val) begin
          if (cnt_q == MAX_C) begin
            ev_overrun = 1'b1;
            state_d    = ST_HUNT;
          end else begin
            state_d = ST_BYTE;
          end
        end else begin
          state_d = ST_HUNT;
          if (cnt_q < MIN_C)      ev_short = 1'b1;
          else if (par_q != 8'h0) ev_crc   = 1'b1;
          else                    ev_good  = 1'b1;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      par_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ev_start) begin
        cnt_q <= '0;
        par_q <= '0;
      end else if (byte_done) begin
        cnt_q <= cnt_q + 1'b1;
        par_q <= parity_add(par_q, byte_nxt);
      end
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || ev_start)
        cap_q[g] <= '0;
      else if (byte_done && cnt_q == CW'(g))
        cap_q[g] <= byte_nxt;
    end
  end

  assign in_hunt = (state_q == ST_HUNT);
  assign in_byte = (state_q == ST_BYTE);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_C);

  assert_one_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_good, ev_short, ev_crc, ev_overrun}));

  assert_byte_then_sep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> state_q == ST_SEP);

endmodule

// File: rtl/dcc_pkt_framer.sv
module dcc_pkt_framer #(
  parameter int MAX_BYTES = 6,
  parameter int MIN_BYTES = 3,
  parameter int PRE_MIN   = 10,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_vld,
  input  logic                   bit_val,
  output logic                   pkt_ok,
  output logic                   pkt_err,
  output logic [CW-1:0]          pkt_len,
  output logic [8*MAX_BYTES-1:0] pkt_bytes
);
  logic                      pre_ok, in_hunt, in_byte, byte_done;
  logic [7:0]                byte_nxt;
  logic [CW-1:0]             cnt_q;
  logic [MAX_BYTES-1:0][7:0] cap_q;
  logic                      ev_good, ev_short, ev_crc, ev_overrun, ev_bad;

  function automatic logic [7:0] fold_all(input logic [8*MAX_BYTES-1:0] v);
    logic [7:0] acc = '0;
    for (int i = 0; i < MAX_BYTES; i++) acc ^= v[8*i +: 8];
    return acc;
  endfunction

  dcc_preamble_det #(.PRE_MIN(PRE_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_vld), .bit_val(bit_val),
    .hunting(in_hunt), .pre_ok(pre_ok)
  );

  dcc_byte_shift u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(bit_vld && in_byte), .in_byte(in_byte),
    .bit_val(bit_val), .byte_done(byte_done), .byte_nxt(byte_nxt)
  );

  dcc_frame_ctl #(.MAX_BYTES(MAX_BYTES), .MIN_BYTES(MIN_BYTES), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_vld), .bit_val(bit_val),
    .pre_ok(pre_ok), .byte_done(byte_done), .byte_nxt(byte_nxt),
    .in_hunt(in_hunt), .in_byte(in_byte), .cnt_q(cnt_q), .cap_q(cap_q),
    .ev_good(ev_good), .ev_short(ev_short), .ev_crc(ev_crc), .ev_overrun(ev_overrun)
  );

  assign ev_bad = ev_short || ev_crc || ev_overrun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_ok    <= 1'b0;
      pkt_err   <= 1'b0;
      pkt_len   <= '0;
      pkt_bytes <= '0;
    end else begin
      pkt_ok  <= ev_good;
      pkt_err <= ev_bad;
      if (ev_good) begin
        pkt_len   <= cnt_q;
        pkt_bytes <= cap_q;
      end
    end
  end

  assert_ok_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |-> (pkt_len >= CW'(MIN_BYTES)) && (pkt_len <= CW'(MAX_BYTES)));

  assert_ok_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |-> fold_all(pkt_bytes) == 8'h0);

  assert_ok_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_ok && pkt_err));

  assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !pkt_ok && !pkt_err);

  assert_err_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |-> $stable(pkt_len) && $stable(pkt_bytes));

endmodule

// File: tb/dcc_pkt_framer_bench.sv
`timescale 1ns/100ps
module dcc_pkt_framer_bench;
  localparam int MAXB = 6;
  localparam int CW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_val = 1'b0;
  logic pkt_ok, pkt_err;
  logic [CW-1:0] pkt_len;
  logic [8*MAXB-1:0] pkt_bytes;

  always #2.5 clk = ~clk;

  dcc_pkt_framer u_dcc_pkt_framer (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .pkt_ok(pkt_ok), .pkt_err(pkt_err), .pkt_len(pkt_len), .pkt_bytes(pkt_bytes)
  );

  int n_chk = 0, n_bad = 0;
  int seen_ok = 0, seen_err = 0;
  int gap_max = 0;
  bit done = 1'b0;
  logic [7:0] pb [0:7];
  logic [CW-1:0] m_len = '0;
  logic [8*MAXB-1:0] m_bytes = '0;

  task automatic chk(input bit good, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    int g = (gap_max == 0) ? 0 : int'($urandom_range(0, gap_max));
    repeat (g) begin
      @(negedge clk); bit_vld = 1'b0; bit_val = 1'($urandom);
    end
    @(negedge clk); bit_vld = 1'b1; bit_val = b;
    @(negedge clk); bit_vld = 1'b0; bit_val = 1'($urandom);
    if (pkt_ok) seen_ok++;
    if (pkt_err) seen_err++;
  endtask

  task automatic send_pkt(input int pre, input int n);
    seen_ok = 0; seen_err = 0;
    repeat (pre) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      for (int k = 7; k >= 0; k--) send_bit(pb[i][k]);
      send_bit(i == n - 1);
    end
  endtask

  function automatic logic [7:0] xor_of(input int n);
    logic [7:0] a = '0;
    for (int i = 0; i < n; i++) a ^= pb[i];
    return a;
  endfunction

  function automatic logic [8*MAXB-1:0] pack_of(input int n);
    logic [8*MAXB-1:0] v = '0;
    for (int i = 0; i < n && i < MAXB; i++) v[8*i +: 8] = pb[i];
    return v;
  endfunction

  // ignored=1: preamble is not valid, expect no strobe at all
  task automatic run_pkt(input int pre, input int n, input bit ignored, input string req);
    bit exp_ok, exp_err;
    send_pkt(pre, n);
    exp_ok  = !ignored && n >= 3 && n <= MAXB && xor_of(n) == 8'h0;
    exp_err = !ignored && !exp_ok;
    if (exp_ok) begin
      m_len = CW'(n);
      m_bytes = pack_of(n);
    end
    chk(seen_ok == int'(exp_ok), req, "ok pulses", 64'(seen_ok), 64'(exp_ok));
    chk(seen_err == int'(exp_err), req, "err pulses", 64'(seen_err), 64'(exp_err));
    chk(pkt_len == m_len, req, "pkt_len", 64'(pkt_len), 64'(m_len));
    chk(pkt_bytes == m_bytes, req, "pkt_bytes", 64'(pkt_bytes), 64'(m_bytes));
  endtask

  task automatic fill_ok(input int n);
    for (int i = 0; i < n - 1; i++) pb[i] = 8'($urandom);
    pb[n-1] = xor_of(n - 1);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!pkt_ok && !pkt_err, "R1", "strobes after reset", 64'({pkt_ok, pkt_err}), 64'd0);
    chk(pkt_len == '0 && pkt_bytes == '0, "R1", "data after reset", 64'(pkt_bytes), 64'd0);

    // R2 R3 R5: exactly PRE_MIN ones, three bytes, MSB first
    pb[0] = 8'hA5; pb[1] = 8'h3C; pb[2] = 8'hA5 ^ 8'h3C;
    run_pkt(10, 3, 1'b0, "R2_R3_R5");
    // R10: nine ones straight after a stop bit must not start a packet
    pb[0] = 8'h12; pb[1] = 8'h34; pb[2] = 8'h26;
    run_pkt(9, 3, 1'b1, "R10");
    // R2: nine ones after idle-time ones cleared by a zero
    send_bit(1'b0);
    run_pkt(9, 3, 1'b1, "R2");
    // R4: maximum length, six bytes
    fill_ok(6);
    run_pkt(12, 6, 1'b0, "R4");
    // R6: corrupted check byte
    fill_ok(4); pb[3] = pb[3] ^ 8'h40;
    run_pkt(11, 4, 1'b0, "R6");
    // R7: two bytes and one byte
    pb[0] = 8'h5A; pb[1] = 8'h5A;
    run_pkt(10, 2, 1'b0, "R7");
    pb[0] = 8'h00;
    run_pkt(10, 1, 1'b0, "R7");
    // R8: seventh byte aborts, then a fresh packet works
    fill_ok(7);
    run_pkt(10, 7, 1'b0, "R8");
    fill_ok(3);
    run_pkt(10, 3, 1'b0, "R8");

    // R9 and random mix: gaps carry random bit_val with bit_vld low
    gap_max = 2;
    for (int t = 0; t < 150; t++) begin
      int n = int'($urandom_range(1, 7));
      fill_ok(n);
      if ($urandom_range(0, 3) == 0) pb[0] = pb[0] ^ 8'(1 << $urandom_range(0, 7));
      run_pkt(int'($urandom_range(10, 15)), n, 1'b0, "R9");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule